// File: doc/BRIEF.md
# Type B Reader Frame Encoder

This block turns a command, presented one byte at a time, into the reader-to-card bit stream of a Type B proximity link, and drives a modulation-enable level at two output slots per coded bit. Each frame is wrapped in a start-of-frame pattern and an end-of-frame pattern. Every byte travels as a character with one start bit and one stop bit. The stream is then filled with ones up to a whole byte of coded bits. CRC bytes, when needed, are part of the input; the encoder does not add them.

Bytes arrive on a valid/ready input with a last flag. The first accepted byte starts a frame. After that the encoder holds one byte in a single staging register, and `in_ready` rises only while that register is empty and the byte flagged last has not yet been taken. The output side has no data pipeline. `out_mod` and `out_valid` are live levels. One slot is consumed on every clock where `tick`, `out_ready` and `out_valid` are all high, so the slot rate is paced by the external tick. Downstream back-pressure (`out_ready` low) freezes the stream on its current slot. If the next byte is not staged when a character boundary is reached, `out_valid` drops until the byte arrives. No slot is lost or repeated while it is low.

Top module: `tbe_reader_encoder`

## Requirements
- R1: A frame begins with a start-of-frame of 10 coded zero bits followed by 2 coded one bits.
- R2: Each input byte is sent as one character: a zero start bit, then the 8 data bits with bit 0 first, then a one stop bit.
- R3: Consecutive characters follow each other directly. The stop bit of one character is followed at once by the start bit of the next, with no extra bits between them.
- R4: After the character of the byte flagged `in_last`, an end-of-frame of 10 coded zero bits followed by 1 coded one bit is sent.
- R5: After end-of-frame, at least 8 coded one bits are sent. More ones follow until the total number of coded bits in the frame is a multiple of 8.
- R6: Each coded bit occupies exactly two consumed slots, both at the same level. A coded 1 gives `out_mod` = 0 and a coded 0 gives `out_mod` = 1.
- R7: A slot is consumed only in a cycle with `tick`, `out_ready` and `out_valid` all high. While `out_ready` is low, `out_mod` holds its value.
- R8: `busy` rises on the clock after the first byte is accepted and falls on the clock after the last padding slot is consumed. After the last byte of a frame is taken, `in_ready` stays low until `busy` falls, so no new frame can start while one is in progress.
- R9: If no byte is staged when a character ends, `out_valid` goes low and no slot is consumed. The stream resumes with the next character once a byte is accepted.
- R10: During and after reset, `busy` = 0, `out_valid` = 0, `out_mod` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slot-rate enable strobe |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Encoder can take a byte |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Byte is the last of the frame |
| out_valid | output | 1 | `out_mod` carries a slot of the frame |
| out_ready | input | 1 | Downstream takes the slot on a tick |
| out_mod | output | 1 | Modulation enable for the current slot |
| busy | output | 1 | A frame is being encoded |

## Verification
The bench rebuilds the expected slot sequence of every frame from the rules above. It compares the start, data, end and padding sections separately, so that wrong framing shows up in the right place. An encoder that added guard ones between characters, or sent data bits in the wrong order, fails the data section. One that padded to the next byte without the 8-bit minimum comes out short and fails the padding length. It also runs frames with a slow tick, with back-pressure that toggles, and with a long `out_ready` stall. A design that consumed slots without ready, or let the level move during a stall, loses slots or drifts. Delayed input bytes force the gap state: a design that kept sending into an empty staging register would emit garbage characters. Each frame also tries to push a byte after the last one, which exposes a design that restarts a frame while still busy.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SOF,
    PH_CHAR,
    PH_GAP,
    PH_EOF,
    PH_PAD
  } phase_t;
endpackage

// File: rtl/tbe_byte_stage.sv
module tbe_byte_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              take,
  output logic              in_ready,
  output logic              accept,
  output logic [DATA_W-1:0] hold,
  output logic              hold_v,
  output logic              last_taken
);
  assign in_ready = !hold_v && (idle || !last_taken);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      hold_v     <= 1'b0;
      last_taken <= 1'b0;
    end else begin
      if (accept) begin
        hold       <= in_data;
        hold_v     <= 1'b1;
        last_taken <= in_last;
      end else if (take) begin
        hold_v <= 1'b0;
      end
    end
  end

  // R9
  take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_v);
endmodule

// File: rtl/tbe_slot_pacer.sv
module tbe_slot_pacer #(
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic out_ready,
  input  logic valid,
  output logic adv,
  output logic bit_done,
  output logic first_slot
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot;

  assign adv        = tick && out_ready && valid;
  assign bit_done   = adv && (slot == SLOT_LAST);
  assign first_slot = (slot == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (adv) begin
      slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end
  end

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot));

  // R6
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> slot == '0);
endmodule

// File: rtl/tbe_framer.sv
module tbe_framer
  import tbe_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SOF_ZEROS = 10,
  parameter int SOF_ONES  = 2,
  parameter int EOF_ZEROS = 10,
  parameter int EOF_ONES  = 1,
  parameter int PAD_MIN   = 8,
  parameter int PACK_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] hold,
  input  logic              hold_v,
  input  logic              last_taken,
  input  logic              bit_done,
  output logic              take,
  output logic              cur_bit,
  output logic              busy,
  output logic              out_valid
);
  localparam int SOF_LEN  = SOF_ZEROS + SOF_ONES;
  localparam int CHAR_LEN = DATA_W + 2;
  localparam int EOF_LEN  = EOF_ZEROS + EOF_ONES;
  localparam int MAX_A    = (SOF_LEN > CHAR_LEN) ? SOF_LEN : CHAR_LEN;
  localparam int MAXLEN   = (MAX_A > EOF_LEN) ? MAX_A : EOF_LEN;
  localparam int CW       = $clog2(MAXLEN);
  localparam int BW       = $clog2(PACK_W);
  localparam int PW       = $clog2(PAD_MIN + 1);

  localparam logic [CW-1:0] SOF_LAST  = CW'(SOF_LEN - 1);
  localparam logic [CW-1:0] CHAR_LAST = CW'(CHAR_LEN - 1);
  localparam logic [CW-1:0] EOF_LAST  = CW'(EOF_LEN - 1);
  localparam logic [CW-1:0] SOF_Z     = CW'(SOF_ZEROS);
  localparam logic [CW-1:0] EOF_Z     = CW'(EOF_ZEROS);
  localparam logic [BW-1:0] BP_LAST   = BW'(PACK_W - 1);
  localparam logic [PW-1:0] PAD_LAST  = PW'(PAD_MIN - 1);

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bitpos;
  logic [PW-1:0]     pad_cnt;
  logic              at_boundary;
  phase_t            bnd_phase;

  assign busy      = (phase != PH_IDLE);
  assign out_valid = busy && (phase != PH_GAP);

  assign at_boundary = bit_done &&
                       (((phase == PH_SOF)  && (cnt == SOF_LAST)) ||
                        ((phase == PH_CHAR) && (cnt == CHAR_LAST)));

  assign take = (at_boundary && hold_v) || ((phase == PH_GAP) && hold_v);

  always_comb begin
    if (hold_v)          bnd_phase = PH_CHAR;
    else if (last_taken) bnd_phase = PH_EOF;
    else                 bnd_phase = PH_GAP;
  end

  always_comb begin
    unique case (phase)
      PH_SOF:  cur_bit = (cnt >= SOF_Z);
      PH_CHAR: begin
        if (cnt == '0)             cur_bit = 1'b0;
        else if (cnt == CHAR_LAST) cur_bit = 1'b1;
        else                       cur_bit = shreg[0];
      end
      PH_EOF:  cur_bit = (cnt >= EOF_Z);
      default: cur_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      bitpos  <= '0;
      pad_cnt <= '0;
    end else begin
      if (bit_done) bitpos <= bitpos + 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase  <= PH_SOF;
            cnt    <= '0;
            bitpos <= '0;
          end
        end
        PH_SOF, PH_CHAR: begin
          if (at_boundary) begin
            cnt   <= '0;
            phase <= bnd_phase;
            if (hold_v) shreg <= hold;
          end else if (bit_done) begin
            cnt <= cnt + 1'b1;
            if ((phase == PH_CHAR) && (cnt != '0)) shreg <= shreg >> 1;
          end
        end
        PH_GAP: begin
          if (hold_v) begin
            phase <= PH_CHAR;
            cnt   <= '0;
            shreg <= hold;
          end
        end
        PH_EOF: begin
          if (bit_done) begin
            if (cnt == EOF_LAST) begin
              phase   <= PH_PAD;
              cnt     <= '0;
              pad_cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_PAD: begin
          if (bit_done) begin
            if ((pad_cnt >= PAD_LAST) && (bitpos == BP_LAST)) phase <= PH_IDLE;
            else if (pad_cnt < PAD_LAST) pad_cnt <= pad_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

  // R5
  pad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bitpos == '0);

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !bit_done) |=> $stable(cur_bit));
endmodule

// File: rtl/tbe_reader_encoder.sv
module tbe_reader_encoder #(
  parameter int DATA_W    = 8,
  parameter int SOF_ZEROS = 10,
  parameter int SOF_ONES  = 2,
  parameter int EOF_ZEROS = 10,
  parameter int EOF_ONES  = 1,
  parameter int PAD_MIN   = 8,
  parameter int PACK_W    = 8,
  parameter int SLOTS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_mod,
  output logic              busy
);
  logic              accept, take, hold_v, last_taken;
  logic [DATA_W-1:0] hold;
  logic              adv, bit_done, first_slot, cur_bit;

  tbe_byte_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .idle(!busy),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .take(take), .in_ready(in_ready), .accept(accept),
    .hold(hold), .hold_v(hold_v), .last_taken(last_taken)
  );

  tbe_framer #(
    .DATA_W(DATA_W), .SOF_ZEROS(SOF_ZEROS), .SOF_ONES(SOF_ONES),
    .EOF_ZEROS(EOF_ZEROS), .EOF_ONES(EOF_ONES),
    .PAD_MIN(PAD_MIN), .PACK_W(PACK_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hold(hold),
    .hold_v(hold_v), .last_taken(last_taken), .bit_done(bit_done),
    .take(take), .cur_bit(cur_bit), .busy(busy), .out_valid(out_valid)
  );

  tbe_slot_pacer #(.SLOTS(SLOTS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .out_ready(out_ready),
    .valid(out_valid), .adv(adv), .bit_done(bit_done),
    .first_slot(first_slot)
  );

  assign out_mod = out_valid && !cur_bit;

  // R6
  pair_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !first_slot) |-> $stable(out_mod));
endmodule

// File: tb/sim_tbe_reader_encoder.sv
`timescale 1ns/1ps
module sim_tbe_reader_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_mod, busy;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tbe_reader_encoder u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_mod(out_mod),
    .busy(busy)
  );

  // {nbytes[3], mode[3], bytes[32] (byte0 in low bits), expected slots[12]}
  // mode 0 full rate, 1 tick every 3rd cycle, 2 toggling ready,
  // 3 delayed input bytes, 4 long ready stall
  localparam logic [49:0] VEC [5] = '{
    {3'd1, 3'd0, 32'h00000005, 12'd96},
    {3'd2, 3'd1, 32'h00003CA5, 12'd112},
    {3'd3, 3'd2, 32'h0081FF00, 12'd128},
    {3'd4, 3'd3, 32'h7EC3501D, 12'd144},
    {3'd1, 3'd4, 32'h000000E7, 12'd96}
  };

  logic exp_s [0:511];
  logic got_s [0:511];
  int   exp_n, got_n, nbits;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_bit(input logic b);
    exp_s[exp_n]     = ~b;
    exp_s[exp_n + 1] = ~b;
    exp_n += 2;
    nbits++;
  endtask

  task automatic build(input int n, input logic [31:0] bv);
    exp_n = 0; nbits = 0;
    for (int i = 0; i < 10; i++) push_bit(1'b0);
    for (int i = 0; i < 2; i++)  push_bit(1'b1);
    for (int k = 0; k < n; k++) begin
      push_bit(1'b0);
      for (int i = 0; i < 8; i++) push_bit(bv[8*k + i]);
      push_bit(1'b1);
    end
    for (int i = 0; i < 10; i++) push_bit(1'b0);
    push_bit(1'b1);
    for (int p = 0; (p < 8) || (nbits % 8 != 0); p++) push_bit(1'b1);
  endtask

  function automatic int seg_bad(input int lo, input int hi);
    int bad = 0;
    for (int i = lo; i < hi; i++) if (got_s[i] !== exp_s[i]) bad++;
    return bad;
  endfunction

  task automatic run_frame(input int n, input int mode, input logic [31:0] bv, input int exp_tab);
    int sent = 0, dly = 0, cyc = 0;
    logic started = 1'b0, gap_seen = 1'b0, late_ready = 1'b0, stall_moved = 1'b0;
    logic ref_mod = 1'b0;
    int stall_cnt0 = 0;
    build(n, bv);
    got_n = 0;
    forever begin
      @(negedge clk);
      tick      = (mode == 1) ? (cyc % 3 == 0) : 1'b1;
      out_ready = (mode == 2) ? cyc[1] : (mode == 4) ? !(cyc >= 30 && cyc < 46) : 1'b1;
      in_valid  = (sent < n) ? ((mode != 3) || (sent == 0) || (dly >= 40)) : (started && busy);
      in_data   = (sent < n) ? bv[8*sent +: 8] : 8'hAA;
      in_last   = (sent >= n - 1);
      #1;
      if (sent >= n && busy && in_ready) late_ready = 1'b1;
      if (sent < n && in_valid && in_ready) begin sent++; dly = 0; end else dly++;
      if (busy) started = 1'b1;
      if (started && busy && !out_valid) gap_seen = 1'b1;
      if (mode == 4 && cyc == 30) begin ref_mod = out_mod; stall_cnt0 = got_n; end
      if (mode == 4 && cyc > 30 && cyc < 46 && out_mod !== ref_mod) stall_moved = 1'b1;
      if (tick && out_ready && out_valid) begin
        if (got_n < 512) got_s[got_n] = out_mod;
        got_n++;
      end
      if (mode == 4 && cyc == 45) chk(got_n == stall_cnt0, "R7 no slot taken without ready", got_n, stall_cnt0);
      if (started && !busy) break;
      cyc++;
      if (cyc > 20000) break;
    end
    in_valid = 1'b0;
    chk(exp_n == exp_tab, "R5 model slot count vs table", exp_n, exp_tab);
    chk(got_n == exp_tab, "R5 frame slot count", got_n, exp_tab);
    if (got_n == exp_n) begin
      chk(seg_bad(0, 24) == 0, "R1 start-of-frame slots", seg_bad(0, 24), 0);
      chk(seg_bad(24, 24 + 20*n) == 0, "R2 R3 R6 character slots", seg_bad(24, 24 + 20*n), 0);
      chk(seg_bad(24 + 20*n, 46 + 20*n) == 0, "R4 end-of-frame slots", seg_bad(24 + 20*n, 46 + 20*n), 0);
      chk(seg_bad(46 + 20*n, exp_n) == 0, "R5 padding slots", seg_bad(46 + 20*n, exp_n), 0);
    end
    chk(!late_ready, "R8 in_ready low after last byte while busy", late_ready, 0);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R8 idle after frame", {in_ready, out_valid}, 2);
    if (mode == 3) chk(gap_seen, "R9 out_valid drops while waiting for byte", gap_seen, 1);
    if (mode == 4) chk(!stall_moved, "R7 out_mod held during stall", stall_moved, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && out_valid === 1'b0 && out_mod === 1'b0 && in_ready === 1'b1,
        "R10 outputs in reset", {busy, out_valid, out_mod, in_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && out_valid === 1'b0 && out_mod === 1'b0 && in_ready === 1'b1,
        "R10 outputs after reset", {busy, out_valid, out_mod, in_ready}, 1);
    for (int v = 0; v < 5; v++) begin
      run_frame(int'(VEC[v][49:47]), int'(VEC[v][46:44]), VEC[v][43:12], int'(VEC[v][11:0]));
      repeat (3) @(negedge clk);
    end
    // idle output with a held tick: nothing consumed, level stays low
    tick = 1'b1; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_mod === 1'b0 && busy === 1'b0, "R7 idle line quiet", {out_mod, busy}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule